// File: doc/BRIEF.md
# Bit-Serial PHY Register Write Engine

This block moves a short value, up to eight bits, into the internal configuration space of an analog PHY. The PHY offers only one 32-bit control register on an ordinary register bus. A caller gives a start pulse with a starting bit address, the data bits, a length, a PHY index from 0 to 3 and a variant select. The engine then sends the bits one at a time, least significant first. Each bit goes through four read-modify-write steps on the control register. The first places the bit address, the second places the data bit, the third raises the commit strobe of the chosen PHY and the fourth drops that strobe again.

The variant select chooses where the control register sits. Class A uses bus offset 0x04. Class B uses bus offset 0x10 and writes the register to zero once before the first bit. The bus port works in single cycles. A read strobe returns data in the following cycle, and a write strobe takes its data in the same cycle. The engine shows `busy_o` while it works and raises `done_o` for one cycle when a job ends.

Top module: `phy_bitser_wr`

## Requirements
- R1: After a synchronous active-low reset, busy_o, done_o, bus_rd_o and bus_wr_o are all 0.
- R2: Each bit takes four steps in this fixed order: address, data, strobe set, strobe clear. Each step is a read strobe, then a quiet cycle in which the read data is captured, then a write strobe to the same offset. One bit therefore takes 12 cycles.
- R3: Each write changes only its own field and keeps every other bit of the value read in that step. The address step puts the bit address in bits 15:8. The data step puts the data bit in bit 7. The set step sets bit 2*n for PHY n, and the clear step clears that bit.
- R4: Data bits go out least significant first. The bit address of bit i is the starting address plus i, modulo 256, so addresses wrap from 0xFF to 0x00.
- R5: With variant 0 every access uses bus offset 0x04. With variant 1 every access uses offset 0x10, and one write of 0x00000000 comes before the first read.
- R6: A start with length 0 makes no bus access, never raises busy_o, and raises done_o in the cycle after the start.
- R7: A length above 8 is treated as 8. Data bits at or above the effective length are never sent.
- R8: A start while busy_o is high is ignored. The running job's accesses, fields and end time do not change, and no second job follows.
- R9: busy_o is high from the cycle after an accepted start through the final strobe-clear write. done_o is high for exactly the next cycle, with busy_o low. That cycle is variant + 12 * length cycles after the accepting edge.
- R10: A read strobe and a write strobe are never active in the same cycle, and the cycle after a read carries no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| variant_i | input | 1 | 0: register at 0x04; 1: register at 0x10 with zero pre-write |
| phy_sel_i | input | 2 | PHY index selecting strobe bit 2*n |
| bit_addr_i | input | 8 | PHY-internal address of the first bit |
| data_i | input | 8 | Data bits, LSB sent first |
| len_i | input | 4 | Number of bits, values above 8 clamp to 8 |
| bus_addr_o | output | 8 | Register bus byte offset |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, valid the cycle after bus_rd_o |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench models the control register as a memory behind the bus port. It starts from values with scattered bits set, so a field write that fails to keep the neighbouring bits shows up. It compares the full access trace against a list built from the requirements. The jobs are chosen so that each one exposes a different fault:
- a single bit on PHY 0 checks the four-step order;
- a five-bit word on PHY 2 checks bit order and the strobe position;
- a class-B job checks the offset and the zero pre-write;
- a run across address 0xFF checks the wrap;
- lengths 0 and 12 check the empty job and the clamp;
- a start pulse in the middle of a job checks that a busy engine ignores it.

// File: rtl/phy_bitser_pkg.sv
// Shared types for the bit-serial PHY register write engine.
// Assumes nothing beyond IEEE 1800-2017 enums.
package phy_bitser_pkg;

    // Sequencer phase: idle, class-B zero pre-write, and the three cycles of
    // one read-modify-write step, then the completion cycle.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ZERO = 3'd1,
        S_RD   = 3'd2,
        S_CAP  = 3'd3,
        S_WR   = 3'd4,
        S_FIN  = 3'd5
    } seq_state_t;

    // Which field a read-modify-write step rewrites, in issue order.
    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_DATA = 2'd1,
        K_SET  = 2'd2,
        K_CLR  = 2'd3
    } step_t;

endpackage

// File: rtl/bitser_seq.sv
// Sequencer of the bit-serial write engine. It accepts a job when idle or
// finishing, latches its parameters, and walks the phases
// (zero pre-write, then read/capture/write for each of four steps per bit).
// Assumes the bus answers a read in the next cycle and never stalls.
module bitser_seq
    import phy_bitser_pkg::*;
#(
    parameter int MAX_BITS = 8,
    parameter int BA_W     = 8,
    parameter int N_PHY    = 4,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int CNT_W   = $clog2(MAX_BITS),
    localparam int PHY_W   = $clog2(N_PHY)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                var_i,
    input  logic [PHY_W-1:0]    phy_i,
    input  logic [BA_W-1:0]     addr_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [LEN_W-1:0]    len_i,
    output seq_state_t          state_o,
    output step_t               step_o,
    output logic [BA_W-1:0]     cur_addr_o,
    output logic                cur_bit_o,
    output logic [PHY_W-1:0]    phy_o,
    output logic                var_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                rd_o,
    output logic                wr_o
);

    seq_state_t            state_q, state_n;
    step_t                 step_q;
    logic [CNT_W-1:0]      bit_q;
    logic [LEN_W-1:0]      len_q;
    logic [BA_W-1:0]       addr_q;
    logic [MAX_BITS-1:0]   data_q;
    logic [PHY_W-1:0]      phy_q;
    logic                  var_q;
    logic [LEN_W-1:0]      len_eff;
    logic                  accept;
    logic                  last_bit;

    // Clamp the requested length to the supported maximum.
    assign len_eff  = (len_i > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len_i;
    // A job is taken only when no job is in flight.
    assign accept   = start_i && (state_q == S_IDLE || state_q == S_FIN);
    // The current bit is the final one of the job.
    assign last_bit = (LEN_W'(bit_q) == len_q - LEN_W'(1));

    // Next-phase selection.
    always_comb begin
        state_n = state_q;
        case (state_q)
            S_IDLE, S_FIN: begin
                if (accept) begin
                    if (len_eff == '0)  state_n = S_FIN;
                    else if (var_i)     state_n = S_ZERO;
                    else                state_n = S_RD;
                end else begin
                    state_n = S_IDLE;
                end
            end
            S_ZERO:  state_n = S_RD;
            S_RD:    state_n = S_CAP;
            S_CAP:   state_n = S_WR;
            S_WR:    state_n = (step_q == K_CLR && last_bit) ? S_FIN : S_RD;
            default: state_n = S_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Job parameter latches, loaded only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            phy_q  <= '0;
            var_q  <= 1'b0;
        end else if (accept) begin
            len_q  <= len_eff;
            addr_q <= addr_i;
            data_q <= data_i;
            phy_q  <= phy_i;
            var_q  <= var_i;
        end
    end

    // Step and bit counters, advanced after each write of a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= K_ADDR;
            bit_q  <= '0;
        end else if (accept) begin
            step_q <= K_ADDR;
            bit_q  <= '0;
        end else if (state_q == S_WR) begin
            if (step_q == K_CLR) begin
                step_q <= K_ADDR;
                bit_q  <= bit_q + CNT_W'(1);
            end else begin
                step_q <= step_t'(step_q + 2'd1);
            end
        end
    end

    // Outputs toward the field builder and the bus port.
    assign state_o    = state_q;
    assign step_o     = step_q;
    assign cur_addr_o = addr_q + BA_W'(bit_q);
    assign cur_bit_o  = data_q[bit_q];
    assign phy_o      = phy_q;
    assign var_o      = var_q;
    assign busy_o     = (state_q == S_ZERO) || (state_q == S_RD) ||
                        (state_q == S_CAP)  || (state_q == S_WR);
    assign done_o     = (state_q == S_FIN);
    assign rd_o       = (state_q == S_RD);
    assign wr_o       = (state_q == S_WR) || (state_q == S_ZERO);

    // R10: read and write strobes are exclusive.
    p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));

    // R10: the cycle after a read carries no access.
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> (!rd_o && !wr_o));

    // R9: completion is never flagged while busy.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: an empty job completes in the next cycle.
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && len_eff == '0) |=> (done_o && !busy_o));

    // R8: a start during a job leaves the latched job untouched.
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> ($stable(addr_q) && $stable(data_q) &&
                                 $stable(len_q) && $stable(phy_q) &&
                                 $stable(var_q)));

endmodule

// File: rtl/bitser_field.sv
// Field builder: forms the write word of the current step from the word
// captured by the preceding read, touching only that step's field.
// Assumes the strobe bits 2*n of all PHYs fit inside the control word.
module bitser_field
    import phy_bitser_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int BA_W     = 8,
    parameter int ADDR_LSB = 8,
    parameter int DATA_POS = 7,
    parameter int N_PHY    = 4,
    localparam int PHY_W   = $clog2(N_PHY)
) (
    input  logic [CTRL_W-1:0] cap_i,
    input  step_t             step_i,
    input  logic [BA_W-1:0]   addr_i,
    input  logic              bit_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic              zero_i,
    output logic [CTRL_W-1:0] wdata_o
);

    localparam logic [CTRL_W-1:0] AMASK =
        ((CTRL_W'(1) << BA_W) - CTRL_W'(1)) << ADDR_LSB;

    logic [N_PHY-1:0]  phy_hit;
    logic [CTRL_W-1:0] stb_mask;

    // One decode line per PHY index.
    for (genvar g = 0; g < N_PHY; g++) begin : g_hit
        assign phy_hit[g] = (phy_i == PHY_W'(g));
    end

    // Strobe mask: bit 2*n for the selected PHY n.
    always_comb begin
        stb_mask = '0;
        for (int g = 0; g < N_PHY; g++) stb_mask[2*g] = phy_hit[g];
    end

    // Merge the step's field into the captured word.
    always_comb begin
        wdata_o = cap_i;
        if (zero_i) begin
            wdata_o = '0;
        end else begin
            case (step_i)
                K_ADDR:  wdata_o = (cap_i & ~AMASK) |
                                   (CTRL_W'(addr_i) << ADDR_LSB);
                K_DATA:  wdata_o[DATA_POS] = bit_i;
                K_SET:   wdata_o = cap_i | stb_mask;
                K_CLR:   wdata_o = cap_i & ~stb_mask;
                default: wdata_o = cap_i;
            endcase
        end
    end

endmodule

// File: rtl/bitser_bus.sv
// Bus-side helper: selects the control-register offset of the job's variant
// and captures read data in the cycle after the read strobe.
// Assumes read data is valid exactly one cycle after the read strobe.
module bitser_bus
    import phy_bitser_pkg::*;
#(
    parameter int                 CTRL_W = 32,
    parameter int                 BUS_AW = 8,
    parameter logic [BUS_AW-1:0]  OFS_A  = 8'h04,
    parameter logic [BUS_AW-1:0]  OFS_B  = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_i,
    input  logic              var_i,
    input  logic              busy_i,
    input  logic [CTRL_W-1:0] rdata_i,
    output logic [CTRL_W-1:0] cap_o,
    output logic [BUS_AW-1:0] addr_o
);

    logic [CTRL_W-1:0] cap_q;

    // Hold the read word for the write that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cap_q <= '0;
        else if (state_i == S_CAP)  cap_q <= rdata_i;
    end

    assign cap_o  = cap_q;
    assign addr_o = var_i ? OFS_B : OFS_A;

    // R5: the offset does not move while a job runs.
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(addr_o));

endmodule

// File: rtl/phy_bitser_wr.sv
// Top of the bit-serial PHY register write engine. It ties the sequencer,
// the field builder and the bus helper to a single-cycle register port.
// Assumes one master owns the control register for the duration of a job.
module phy_bitser_wr
    import phy_bitser_pkg::*;
#(
    parameter int                MAX_BITS = 8,
    parameter int                BA_W     = 8,
    parameter int                N_PHY    = 4,
    parameter int                CTRL_W   = 32,
    parameter int                BUS_AW   = 8,
    parameter int                ADDR_LSB = 8,
    parameter int                DATA_POS = 7,
    parameter logic [BUS_AW-1:0] OFS_A    = 8'h04,
    parameter logic [BUS_AW-1:0] OFS_B    = 8'h10,
    localparam int LEN_W = $clog2(MAX_BITS + 1),
    localparam int PHY_W = $clog2(N_PHY)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                variant_i,
    input  logic [PHY_W-1:0]    phy_sel_i,
    input  logic [BA_W-1:0]     bit_addr_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic [BUS_AW-1:0]   bus_addr_o,
    output logic                bus_rd_o,
    output logic                bus_wr_o,
    output logic [CTRL_W-1:0]   bus_wdata_o,
    input  logic [CTRL_W-1:0]   bus_rdata_i,
    output logic                busy_o,
    output logic                done_o
);

    seq_state_t        state;
    step_t             step;
    logic [BA_W-1:0]   cur_addr;
    logic              cur_bit;
    logic [PHY_W-1:0]  phy;
    logic              var_sel;
    logic [CTRL_W-1:0] cap;

    bitser_seq #(
        .MAX_BITS (MAX_BITS),
        .BA_W     (BA_W),
        .N_PHY    (N_PHY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .var_i      (variant_i),
        .phy_i      (phy_sel_i),
        .addr_i     (bit_addr_i),
        .data_i     (data_i),
        .len_i      (len_i),
        .state_o    (state),
        .step_o     (step),
        .cur_addr_o (cur_addr),
        .cur_bit_o  (cur_bit),
        .phy_o      (phy),
        .var_o      (var_sel),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .rd_o       (bus_rd_o),
        .wr_o       (bus_wr_o)
    );

    bitser_bus #(
        .CTRL_W (CTRL_W),
        .BUS_AW (BUS_AW),
        .OFS_A  (OFS_A),
        .OFS_B  (OFS_B)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .var_i   (var_sel),
        .busy_i  (busy_o),
        .rdata_i (bus_rdata_i),
        .cap_o   (cap),
        .addr_o  (bus_addr_o)
    );

    bitser_field #(
        .CTRL_W   (CTRL_W),
        .BA_W     (BA_W),
        .ADDR_LSB (ADDR_LSB),
        .DATA_POS (DATA_POS),
        .N_PHY    (N_PHY)
    ) u_field (
        .cap_i   (cap),
        .step_i  (step),
        .addr_i  (cur_addr),
        .bit_i   (cur_bit),
        .phy_i   (phy),
        .zero_i  (state == S_ZERO),
        .wdata_o (bus_wdata_o)
    );

    // R1: reset leaves the port quiet.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !bus_rd_o && !bus_wr_o));

    // R9: completion lasts one cycle unless a new empty job is taken.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

endmodule

// File: tb/phy_bitser_wr_test.sv
`timescale 1ns/1ps
// Directed bench: a memory model of both control-register offsets sits on
// the bus port; each scenario task builds the expected access trace from the
// requirements and compares it.
module phy_bitser_wr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        variant_i = 1'b0;
    logic [1:0]  phy_sel_i = '0;
    logic [7:0]  bit_addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [3:0]  len_i = '0;
    logic [7:0]  bus_addr_o;
    logic        bus_rd_o, bus_wr_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        busy_o, done_o;

    int checks = 0;
    int fails  = 0;

    logic [31:0] ctl_a = 32'h5A3C_0F0F;
    logic [31:0] ctl_b = 32'hC3C3_00AA;
    bit          tr_w [512];
    logic [7:0]  tr_a [512];
    logic [31:0] tr_d [512];
    int          ntr = 0;
    bit          both_seen = 1'b0;

    always #10 clk = ~clk;

    phy_bitser_wr uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
        .phy_sel_i(phy_sel_i), .bit_addr_i(bit_addr_i), .data_i(data_i),
        .len_i(len_i), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
        .bus_wr_o(bus_wr_o), .bus_wdata_o(bus_wdata_o),
        .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o)
    );

    // Register model and access trace recorder.
    always @(posedge clk) begin
        bus_rdata_i <= '0;
        if (rst_n) begin
            if (bus_rd_o && bus_wr_o) both_seen <= 1'b1;
            if ((bus_rd_o || bus_wr_o) && ntr < 512) begin
                tr_w[ntr] <= bus_wr_o;
                tr_a[ntr] <= bus_addr_o;
                tr_d[ntr] <= bus_wdata_o;
                ntr <= ntr + 1;
            end
            if (bus_rd_o) bus_rdata_i <= (bus_addr_o == 8'h10) ? ctl_b : ctl_a;
            if (bus_wr_o) begin
                if (bus_addr_o == 8'h04) ctl_a <= bus_wdata_o;
                else if (bus_addr_o == 8'h10) ctl_b <= bus_wdata_o;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Run one job, optionally pulsing a foreign start at cycle 'poke'.
    task automatic run_job(input bit v, input logic [1:0] p, input logic [7:0] a,
                           input logic [7:0] d, input logic [3:0] l,
                           input int poke, input string req);
        bit          ew [80];
        logic [7:0]  ea [80];
        logic [31:0] ed [80];
        int          ne = 0;
        int          leff = (l > 8) ? 8 : int'(l);
        logic [7:0]  ofs = v ? 8'h10 : 8'h04;
        logic [31:0] m = v ? ctl_b : ctl_a;
        int          base = ntr;
        int          n = 0;
        int          bad_busy = 0;
        int          bad_tr = 0;
        int          exp_cyc = (leff == 0) ? 0 : int'(v) + 12 * leff;

        if (leff > 0 && v) begin
            ew[ne] = 1'b1; ea[ne] = ofs; ed[ne] = '0; ne++;
            m = '0;
        end
        for (int i = 0; i < leff; i++) begin
            for (int s = 0; s < 4; s++) begin
                ew[ne] = 1'b0; ea[ne] = ofs; ed[ne] = '0; ne++;
                case (s)
                    0: m = (m & ~32'h0000_FF00) | ({24'd0, 8'(a + i)} << 8);
                    1: m[7] = d[i];
                    2: m[2*p] = 1'b1;
                    default: m[2*p] = 1'b0;
                endcase
                ew[ne] = 1'b1; ea[ne] = ofs; ed[ne] = m; ne++;
            end
        end

        @(negedge clk);
        variant_i = v; phy_sel_i = p; bit_addr_i = a; data_i = d; len_i = l;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && n < 2000) begin
            if (!busy_o) bad_busy++;
            start_i = (n == poke);
            if (n == poke) begin
                variant_i = ~v; phy_sel_i = p ^ 2'd1; bit_addr_i = 8'h77;
                data_i = 8'hFF; len_i = 4'd8;
            end
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        chk(bad_busy == 0, "R9", {req, " busy low inside job"}, bad_busy, 0);
        chk(!busy_o, "R9", {req, " busy at done"}, busy_o, 0);
        chk(n == exp_cyc, "R9", {req, " done latency"}, n, exp_cyc);
        @(posedge clk);
        @(negedge clk);
        chk(!done_o, "R9", {req, " done pulse width"}, done_o, 0);
        repeat (3) @(negedge clk);
        chk(ntr - base == ne, req, "access count", ntr - base, ne);
        for (int k = 0; k < ne && base + k < ntr; k++) begin
            if (tr_w[base+k] != ew[k] || tr_a[base+k] != ea[k] ||
                (ew[k] && tr_d[base+k] != ed[k])) begin
                if (bad_tr == 0)
                    chk(1'b0, req, $sformatf("access %0d (w%0d @%0h)", k,
                        tr_w[base+k], tr_a[base+k]), tr_d[base+k], ed[k]);
                bad_tr++;
            end
        end
        if (bad_tr == 0) chk(1'b1, req, "trace", 0, 0);
        chk((v ? ctl_b : ctl_a) == m, "R3", {req, " final register"},
            v ? ctl_b : ctl_a, m);
        chk(!both_seen, "R10", "read and write together", both_seen, 0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o, "R1", "busy/done after reset", {busy_o, done_o}, 0);
        chk(!bus_rd_o && !bus_wr_o, "R1", "strobes after reset",
            {bus_rd_o, bus_wr_o}, 0);
    endtask

    // R2 R3: one bit on PHY 0, class A.
    task automatic t_single_bit();
        run_job(1'b0, 2'd0, 8'h0C, 8'h01, 4'd1, -1, "R2");
    endtask

    // R4 R3: five bits LSB first on PHY 2.
    task automatic t_multi_bit();
        run_job(1'b0, 2'd2, 8'h20, 8'h14, 4'd5, -1, "R4");
    endtask

    // R5: class B offset and zero pre-write.
    task automatic t_variant_b();
        run_job(1'b1, 2'd1, 8'h2A, 8'h03, 4'd2, -1, "R5");
    endtask

    // R4: bit address wraps past 0xFF.
    task automatic t_wrap();
        run_job(1'b1, 2'd3, 8'hFE, 8'hA5, 4'd4, -1, "R4");
    endtask

    // R6: empty jobs on both classes.
    task automatic t_zero_len();
        run_job(1'b0, 2'd1, 8'h10, 8'hFF, 4'd0, -1, "R6");
        run_job(1'b1, 2'd2, 8'h33, 8'hFF, 4'd0, -1, "R6");
    endtask

    // R7: length 12 behaves as 8.
    task automatic t_clamp();
        run_job(1'b0, 2'd3, 8'h40, 8'h5A, 4'd12, -1, "R7");
    endtask

    // R8: foreign start mid-job.
    task automatic t_busy_start();
        run_job(1'b0, 2'd1, 8'h60, 8'h02, 4'd2, 5, "R8");
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bit();
        t_multi_bit();
        t_variant_b();
        t_wrap();
        t_zero_len();
        t_clamp();
        t_busy_start();
        summary();
        $finish;
    end

endmodule